// File: doc/BRIEF.md
# Energy-Detect Power-Down Link Pulse Controller

This block governs link-pulse activity while a port sits in its energy-detect power-down state. When transmit pulsing is enabled, it emits a one-cycle transmit-pulse strobe at a regular spacing during power-down. A 2-bit select field picks that spacing from a four-entry table of cycle counts set by parameters.

On the receive side, the block watches a one-cycle strobe from the pulse detector and issues a one-cycle wake request. It can wake in one of two ways. In single-pulse mode, one detected pulse is enough. In pair mode, two pulses must arrive no more than a chosen number of cycles apart. That maximum gap comes from a second four-entry table, indexed by its own 2-bit field.

When power-down ends, all timers and any pending first pulse are cleared.

Top module: `edpd_pulse_ctrl`

## Requirements
- R1: `tx_pulse` stays low in every cycle unless both `pd_active` and `tx_pulse_en` were high at the preceding clock edge.
- R2: With power-down active and transmit pulsing enabled, `tx_pulse` is high for one cycle every N cycles. N is `TX_IVL0`..`TX_IVL3`, selected by `tx_ivl_sel` = 0..3. The first strobe comes N cycles after the first edge at which both inputs are high.
- R3: With `rx_single_wake` = 1, one `rx_pulse` sampled during power-down raises `wake` in the following cycle.
- R4: With `rx_single_wake` = 0, `wake` rises in the cycle after a second `rx_pulse`, provided it is sampled G cycles after the first with G <= W. W is `RX_WIN0`..`RX_WIN3`, selected by `rx_win_sel` = 0..3. The first pulse alone does not raise `wake`.
- R5: In pair mode, a second pulse with G > W does not wake. It is taken as a new first pulse and restarts the window.
- R6: `wake` lasts exactly one cycle. No further wake is issued until `pd_active` has gone low and high again.
- R7: When `pd_active` is sampled low, transmit strobes stop and the pending first pulse is discarded. The pending pulse therefore does not count toward a wake after power-down is re-entered.
- R8: `rx_pulse` strobes sampled while `pd_active` is low never cause a wake.
- R9: After reset (`rst_n` low), `tx_pulse` and `wake` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pd_active | input | 1 | Port is in energy-detect power-down |
| tx_pulse_en | input | 1 | Enable periodic transmit link pulses |
| tx_ivl_sel | input | 2 | Index into the transmit spacing table |
| rx_single_wake | input | 1 | 1: wake on one pulse; 0: wake on a timed pair |
| rx_win_sel | input | 2 | Index into the pair-gap table |
| rx_pulse | input | 1 | One-cycle strobe for a detected link pulse |
| tx_pulse | output | 1 | One-cycle strobe requesting a transmit link pulse |
| wake | output | 1 | One-cycle wake request |

## Verification
The embedded assertions check these properties on every cycle:
- transmit strobes are gated by power-down and the enable;
- wake is one cycle long and always follows a pulse seen during power-down;
- both outputs fall silent after power-down is sampled low;
- single-pulse and in-window pair detections produce a wake.

Only the bench scenarios can show the exact transmit spacing for each table entry and the exact pair-window boundary. The same applies to re-arming after a late second pulse and to discarding a pending pulse across a power-down exit.

// File: rtl/edpd_pulse_ctrl.sv
module edpd_pulse_ctrl #(
  parameter int CNT_W   = 16,
  parameter int TX_IVL0 = 1000,
  parameter int TX_IVL1 = 2000,
  parameter int TX_IVL2 = 4000,
  parameter int TX_IVL3 = 8000,
  parameter int RX_WIN0 = 500,
  parameter int RX_WIN1 = 1000,
  parameter int RX_WIN2 = 2000,
  parameter int RX_WIN3 = 4000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pd_active,
  input  logic       tx_pulse_en,
  input  logic [1:0] tx_ivl_sel,
  input  logic       rx_single_wake,
  input  logic [1:0] rx_win_sel,
  input  logic       rx_pulse,
  output logic       tx_pulse,
  output logic       wake
);

  logic [CNT_W-1:0] tx_ivl, rx_win, tx_cnt, win_cnt;
  logic             armed, woke;
  logic             tx_run;

  assign tx_run = pd_active & tx_pulse_en;

  always_comb begin
    case (tx_ivl_sel)
      2'd0:    tx_ivl = CNT_W'(TX_IVL0);
      2'd1:    tx_ivl = CNT_W'(TX_IVL1);
      2'd2:    tx_ivl = CNT_W'(TX_IVL2);
      default: tx_ivl = CNT_W'(TX_IVL3);
    endcase
    case (rx_win_sel)
      2'd0:    rx_win = CNT_W'(RX_WIN0);
      2'd1:    rx_win = CNT_W'(RX_WIN1);
      2'd2:    rx_win = CNT_W'(RX_WIN2);
      default: rx_win = CNT_W'(RX_WIN3);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_cnt   <= '0;
      tx_pulse <= 1'b0;
    end else if (!tx_run) begin
      tx_cnt   <= '0;
      tx_pulse <= 1'b0;
    end else if (tx_cnt >= tx_ivl - 1'b1) begin
      tx_cnt   <= '0;
      tx_pulse <= 1'b1;
    end else begin
      tx_cnt   <= tx_cnt + 1'b1;
      tx_pulse <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      win_cnt <= '0;
      woke    <= 1'b0;
      wake    <= 1'b0;
    end else if (!pd_active) begin
      armed   <= 1'b0;
      win_cnt <= '0;
      woke    <= 1'b0;
      wake    <= 1'b0;
    end else begin
      wake <= 1'b0;
      if (!woke) begin
        if (rx_pulse) begin
          if (rx_single_wake || armed) begin
            wake  <= 1'b1;
            woke  <= 1'b1;
            armed <= 1'b0;
          end else begin
            armed   <= 1'b1;
            win_cnt <= CNT_W'(1);
          end
        end else if (armed) begin
          if (win_cnt >= rx_win) armed <= 1'b0;
          else                   win_cnt <= win_cnt + 1'b1;
        end
      end
    end
  end

  p_tx_gated_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_run |=> !tx_pulse);

  p_single_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pd_active && rx_single_wake && rx_pulse && !woke |=> wake);

  p_pair_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pd_active && !rx_single_wake && armed && rx_pulse && !woke |=> wake);

  p_late_rearm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pd_active && armed && !rx_pulse && !woke && win_cnt >= rx_win |=> !armed);

  p_wake_single_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_active |=> !wake && !tx_pulse && !armed);

  p_wake_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> $past(rx_pulse && pd_active));

endmodule

// File: tb/test_edpd_pulse_ctrl.sv
module test_edpd_pulse_ctrl;
  localparam int TXI [4] = '{3, 5, 7, 10};
  localparam int RXW [4] = '{2, 4, 6, 9};

  logic clk = 1'b0, rst_n = 1'b0;
  logic pd_active = 1'b0, tx_pulse_en = 1'b0, rx_single_wake = 1'b0, rx_pulse = 1'b0;
  logic [1:0] tx_ivl_sel = 2'd0, rx_win_sel = 2'd0;
  logic tx_pulse, wake;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  edpd_pulse_ctrl #(.CNT_W(8),
    .TX_IVL0(3), .TX_IVL1(5), .TX_IVL2(7), .TX_IVL3(10),
    .RX_WIN0(2), .RX_WIN1(4), .RX_WIN2(6), .RX_WIN3(9)) i_edpd_pulse_ctrl (
    .clk(clk), .rst_n(rst_n), .pd_active(pd_active), .tx_pulse_en(tx_pulse_en),
    .tx_ivl_sel(tx_ivl_sel), .rx_single_wake(rx_single_wake), .rx_win_sel(rx_win_sel),
    .rx_pulse(rx_pulse), .tx_pulse(tx_pulse), .wake(wake));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic pd_cycle();
    pd_active = 1'b0; tick(); tick();
    pd_active = 1'b1;
  endtask

  task automatic pulse_and_check(input string req, input logic exp_wake);
    rx_pulse = 1'b1; tick(); chk(req, wake, exp_wake); rx_pulse = 1'b0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tick();
    chk("R9 tx", tx_pulse, 1'b0);
    chk("R9 wake", wake, 1'b0);
    rst_n = 1'b1; tick();

    // R1: power-down without enable, and enable without power-down
    pd_active = 1'b1; tx_pulse_en = 1'b0;
    for (int n = 0; n < 25; n++) begin tick(); chk("R1 no enable", tx_pulse, 1'b0); end
    pd_active = 1'b0; tx_pulse_en = 1'b1;
    for (int n = 0; n < 25; n++) begin tick(); chk("R1 no pd", tx_pulse, 1'b0); end

    // R2: spacing sweep over all table entries
    for (int s = 0; s < 4; s++) begin
      pd_active = 1'b0; tick(); tick();
      tx_ivl_sel = 2'(s); pd_active = 1'b1;
      for (int n = 1; n <= 3 * TXI[s]; n++) begin
        tick();
        chk($sformatf("R2 sel%0d n%0d", s, n), tx_pulse, (n % TXI[s]) == 0);
      end
    end

    // R7: leaving power-down stops transmit strobes
    pd_active = 1'b0;
    for (int n = 0; n < 12; n++) begin tick(); chk("R7 tx stop", tx_pulse, 1'b0); end
    tx_pulse_en = 1'b0;

    // R3 and R6: single-pulse wake, then no second wake
    rx_single_wake = 1'b1; pd_cycle();
    tick();
    pulse_and_check("R3 single", 1'b1);
    tick(); chk("R6 one cycle", wake, 1'b0);
    pulse_and_check("R6 no rewake", 1'b0);
    tick(); chk("R6 no rewake", wake, 1'b0);

    // R4 and R5: gap sweep for every window entry
    rx_single_wake = 1'b0;
    for (int s = 0; s < 4; s++) begin
      rx_win_sel = 2'(s);
      for (int g = 1; g <= RXW[s] + 2; g++) begin
        pd_cycle(); tick();
        pulse_and_check("R4 first alone", 1'b0);
        for (int k = 1; k < g; k++) begin tick(); chk("R4 between", wake, 1'b0); end
        pulse_and_check($sformatf("R4 win%0d gap%0d", s, g), g <= RXW[s]);
        if (g > RXW[s]) begin
          // R5: the late pulse re-armed the window
          pulse_and_check($sformatf("R5 rearm win%0d gap%0d", s, g), 1'b1);
        end
        tick(); chk("R6 one cycle", wake, 1'b0);
        pulse_and_check("R6 no rewake", 1'b0);
        pulse_and_check("R6 no rewake", 1'b0);
      end
    end

    // R7: pending first pulse is discarded across a power-down exit
    rx_win_sel = 2'd3; pd_cycle(); tick();
    pulse_and_check("R7 arm", 1'b0);
    pd_active = 1'b0; tick();
    pd_active = 1'b1; tick();
    pulse_and_check("R7 cleared", 1'b0);
    tick(); chk("R7 cleared", wake, 1'b0);

    // R8: pulses outside power-down are ignored in both modes
    pd_active = 1'b0; tick();
    rx_single_wake = 1'b1;
    pulse_and_check("R8 single idle", 1'b0);
    tick(); chk("R8 single idle", wake, 1'b0);
    rx_single_wake = 1'b0;
    pulse_and_check("R8 pair idle", 1'b0);
    pd_active = 1'b1;
    pulse_and_check("R8 pair not stored", 1'b0);
    tick(); chk("R8 pair not stored", wake, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule